// File: doc/BRIEF.md
# Bit-Slip Word Aligner with Training Controller

This block restores the byte boundary of one channel of parallel words coming from an upstream deserializer. The incoming words are already clock-synchronous and phase-aligned, but the bit that the deserializer placed at position 0 may not be the first bit of a character. A registered slip stage joins the previous and current raw words into a double-width window and delivers one word-wide slice of it. A slip moves that slice by one bit.

A training controller watches every delivered word while it hunts. It compares each word against a programmable training pattern. On a mismatch it raises a one-clock slip request. It then lets the pipeline flush for a fixed number of words before it compares again. After a run of consecutive matches it declares lock. If it has slipped through every position without success, it declares failure. An external align level is ORed with the controller's request, so software or a pin can also step the boundary by hand. A synchronous restart starts the search over. Each channel uses its own instance, so each keeps its own slip state.

Top module: `wa_word_aligner`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is low, `out_word` holds its last value.
- R2: With slip offset k, the delivered word is bits k..k+7 of the 16-bit window {previous valid word, current word}, where the current word is the low byte. For a constant input word c, this gives c rotated right by k.
- R3: Each rising edge of the combined request (controller request OR `ext_align`) advances the offset by exactly one, modulo 8. The new offset applies from the next captured word onward. Eight slips bring the output back to the unslipped word.
- R4: A request level that stays high causes no further slips. While `ext_align` is held high, controller requests produce no slip and the output rotation stays unchanged.
- R5: While hunting, each valid delivered word that differs from `pattern` causes one controller slip request and increments `slip_count` by one.
- R6: After each controller slip request, and after reset or restart, the controller discards the next 3 valid words before it compares again. With `in_valid` held high, successive `slip_count` increments are 4 clocks apart.
- R7: `locked` rises after 4 consecutive matching words. It then stays high and the controller issues no more requests until restart. At lock, `out_word` equals `pattern` and `slip_count` equals the number of slips needed.
- R8: A mismatch seen when `slip_count` is already 8 raises `fail`. `slip_count` then stays at 8, and `locked` and `fail` are never high together.
- R9: `restart` clears the offset, `locked`, `fail` and `slip_count`, and starts a new search from offset 0.
- R10: After reset, `out_valid`, `locked`, `fail` and `slip_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| restart | input | 1 | Synchronous restart of the search |
| in_valid | input | 1 | Raw word present |
| in_word | input | 8 | Raw word from deserializer |
| pattern | input | 8 | Training pattern |
| ext_align | input | 1 | External align level, ORed and edge-detected |
| out_word | output | 8 | Realigned word |
| out_valid | output | 1 | Realigned word present |
| locked | output | 1 | Boundary found |
| fail | output | 1 | No boundary after all slips |
| slip_count | output | 4 | Slips issued by the controller |

## Verification
The two request sources can be active in the same cycle: the controller's one-clock slip request and a high level on the external align input. Because both feed a single edge detector, they merge into one edge. The bench provokes this by raising `ext_align` before a restart and holding it high through an entire hunt. It then judges the result at the ports: `fail` rises with `slip_count` at 8, and `out_word` stays equal to the unrotated input, which shows that none of the eight controller requests moved the boundary.

// File: rtl/wa_pkg.sv
package wa_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOCKED = 2'd2,
    ST_FAIL   = 2'd3
  } wa_state_e;

  // Next slip offset, wrapping at the word width.
  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // Saturating increment used by counters.
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/wa_slip_stage.sv
module wa_slip_stage #(
  parameter int WORD_W = 8,
  localparam int OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              slip_pulse,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  output logic [OFF_W-1:0]  offset
);

  logic [WORD_W-1:0]   prev_q;
  logic [OFF_W-1:0]    off_q;
  logic [2*WORD_W-1:0] window;
  logic [WORD_W-1:0]   cand [WORD_W];

  assign window = {prev_q, in_word};

  // One candidate slice per offset.
  for (genvar k = 0; k < WORD_W; k++) begin : g_cand
    assign cand[k] = window[k +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      off_q     <= '0;
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        prev_q   <= in_word;
        out_word <= cand[off_q];
      end
      if (restart)
        off_q <= '0;
      else if (slip_pulse)
        off_q <= OFF_W'(wa_pkg::wrap_next(int'(off_q), WORD_W));
    end
  end

  assign offset = off_q;

endmodule

// File: rtl/wa_align_edge.sv
module wa_align_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_req,
  input  logic ext_align,
  output logic req_level,
  output logic slip_pulse
);

  logic req_q;

  assign req_level  = ctrl_req | ext_align;
  assign slip_pulse = req_level & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_level;
  end

endmodule

// File: rtl/wa_align_ctrl.sv
module wa_align_ctrl #(
  parameter int WORD_W       = 8,
  parameter int SETTLE_WORDS = 3,
  parameter int LOCK_WORDS   = 4,
  parameter int MAX_SLIPS    = 8,
  localparam int CNT_W = $clog2(MAX_SLIPS + 1),
  localparam int SET_W = (SETTLE_WORDS > 1) ? $clog2(SETTLE_WORDS) : 1,
  localparam int MAT_W = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] pattern,
  output logic              align_req,
  output logic              locked,
  output logic              fail,
  output logic [CNT_W-1:0]  slip_count
);
  import wa_pkg::*;

  wa_state_e        state_q;
  logic [SET_W-1:0] settle_q;
  logic [MAT_W-1:0] match_q;
  logic [CNT_W-1:0] slips_q;
  logic             req_q;
  logic             hit;

  assign hit = (word == pattern);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      state_q  <= ST_SETTLE;
      settle_q <= '0;
      match_q  <= '0;
      slips_q  <= '0;
      req_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      case (state_q)
        ST_HUNT: if (word_valid) begin
          if (hit) begin
            if (int'(match_q) == LOCK_WORDS - 1) begin
              state_q <= ST_LOCKED;
              match_q <= '0;
            end else begin
              match_q <= match_q + 1'b1;
            end
          end else begin
            match_q <= '0;
            if (int'(slips_q) >= MAX_SLIPS) begin
              state_q <= ST_FAIL;
            end else begin
              req_q    <= 1'b1;
              slips_q  <= slips_q + 1'b1;
              settle_q <= '0;
              state_q  <= ST_SETTLE;
            end
          end
        end
        ST_SETTLE: if (word_valid) begin
          if (int'(settle_q) >= SETTLE_WORDS - 1) state_q <= ST_HUNT;
          else settle_q <= settle_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign align_req  = req_q;
  assign locked     = (state_q == ST_LOCKED);
  assign fail       = (state_q == ST_FAIL);
  assign slip_count = slips_q;

endmodule

// File: rtl/wa_word_aligner.sv
module wa_word_aligner #(
  parameter int WORD_W       = 8,
  parameter int SETTLE_WORDS = 3,
  parameter int LOCK_WORDS   = 4,
  parameter int MAX_SLIPS    = 8,
  localparam int CNT_W = $clog2(MAX_SLIPS + 1),
  localparam int OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [WORD_W-1:0] pattern,
  input  logic              ext_align,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  output logic              locked,
  output logic              fail,
  output logic [CNT_W-1:0]  slip_count
);

  // Named internal events, observed by the bound checker.
  logic             ctrl_req;
  logic             req_level;
  logic             slip_pulse;
  logic [OFF_W-1:0] offset;

  wa_align_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_req  (ctrl_req),
    .ext_align (ext_align),
    .req_level (req_level),
    .slip_pulse(slip_pulse)
  );

  wa_slip_stage #(.WORD_W(WORD_W)) u_slip (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .slip_pulse(slip_pulse),
    .out_word  (out_word),
    .out_valid (out_valid),
    .offset    (offset)
  );

  wa_align_ctrl #(
    .WORD_W      (WORD_W),
    .SETTLE_WORDS(SETTLE_WORDS),
    .LOCK_WORDS  (LOCK_WORDS),
    .MAX_SLIPS   (MAX_SLIPS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .word_valid(out_valid),
    .word      (out_word),
    .pattern   (pattern),
    .align_req (ctrl_req),
    .locked    (locked),
    .fail      (fail),
    .slip_count(slip_count)
  );

endmodule

// File: rtl/wa_word_aligner_chk.sv
module wa_word_aligner_chk #(
  parameter int WORD_W       = 8,
  parameter int SETTLE_WORDS = 3,
  parameter int MAX_SLIPS    = 8,
  localparam int CNT_W = $clog2(MAX_SLIPS + 1),
  localparam int OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  localparam int GAP_W = $clog2(SETTLE_WORDS + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             in_valid,
  input logic             out_valid,
  input logic             slip_pulse,
  input logic             ctrl_req,
  input logic [OFF_W-1:0] offset,
  input logic             locked,
  input logic             fail,
  input logic [CNT_W-1:0] slip_count
);

  logic             past_ok;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      gap_q   <= GAP_W'(SETTLE_WORDS);
    end else begin
      past_ok <= 1'b1;
      if (restart)       gap_q <= GAP_W'(SETTLE_WORDS);
      else if (ctrl_req) gap_q <= '0;
      else               gap_q <= GAP_W'(wa_pkg::sat_inc(int'(gap_q), SETTLE_WORDS));
    end
  end

  // R1
  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> out_valid == $past(in_valid));

  // R3
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_pulse && !restart) |=> offset == OFF_W'(wa_pkg::wrap_next(int'($past(offset)), WORD_W)));

  // R4
  a_r4_no_edge_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!slip_pulse && !restart) |=> $stable(offset));

  // R6
  a_r6_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_req |-> int'(gap_q) >= SETTLE_WORDS);

  // R7
  a_r7_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !ctrl_req);

  // R8
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && fail));

  // R8
  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slip_count) <= MAX_SLIPS);

  // R9
  a_r9_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (offset == '0) && !locked && !fail && (slip_count == '0));

endmodule

bind wa_word_aligner wa_word_aligner_chk #(
  .WORD_W      (WORD_W),
  .SETTLE_WORDS(SETTLE_WORDS),
  .MAX_SLIPS   (MAX_SLIPS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .slip_pulse(slip_pulse),
  .ctrl_req  (ctrl_req),
  .offset    (offset),
  .locked    (locked),
  .fail      (fail),
  .slip_count(slip_count)
);

// File: tb/test_wa_word_aligner.sv
module test_wa_word_aligner;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_word = '0;
  logic [7:0] pattern = '0;
  logic       ext_align = 1'b0;
  logic [7:0] out_word;
  logic       out_valid;
  logic       locked;
  logic       fail;
  logic [3:0] slip_count;

  int checks = 0;
  int failures = 0;

  localparam logic [7:0] TRAIN = 8'h1D;

  always #10 clk = ~clk;

  wa_word_aligner i_wa_word_aligner (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
    .in_word(in_word), .pattern(pattern), .ext_align(ext_align),
    .out_word(out_word), .out_valid(out_valid), .locked(locked),
    .fail(fail), .slip_count(slip_count)
  );

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[(i + n) % 8] = v[i];
    return r;
  endfunction

  function automatic logic [7:0] rotr(input logic [7:0] v, input int n);
    return rotl(v, (8 - (n % 8)) % 8);
  endfunction

  // Slice of {prev, cur} starting at bit k; cur is the low byte.
  function automatic logic [7:0] slice(input logic [7:0] prv, input logic [7:0] cur, input int k);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = (i + k < 8) ? cur[i + k] : prv[i + k - 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart_pulse();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic wait_for(input bit want_lock, input string req, output int cycles);
    cycles = 0;
    while (((want_lock ? locked : fail) !== 1'b1) && cycles < 400) begin
      @(negedge clk);
      cycles++;
    end
    check(cycles < 400, req, cycles, 400);
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0, "R10 out_valid", out_valid, 0);
    check(locked === 1'b0, "R10 locked", locked, 0);
    check(fail === 1'b0, "R10 fail", fail, 0);
    check(slip_count === 4'd0, "R10 slip_count", slip_count, 0);
  endtask

  task automatic t_lock(input int rot);
    int cyc;
    int last_chg;
    int prev_cnt;
    int n;
    pattern = TRAIN;
    in_word = rotl(TRAIN, rot);
    in_valid = 1'b1;
    restart_pulse();
    check(slip_count === 4'd0 && !locked, "R9 cleared by restart", slip_count, 0);
    last_chg = -1;
    prev_cnt = 0;
    n = 0;
    while (locked !== 1'b1 && n < 400) begin
      @(negedge clk);
      n++;
      if (int'(slip_count) != prev_cnt) begin
        if (last_chg >= 0)
          check(n - last_chg == 4, "R6 request spacing", n - last_chg, 4);
        last_chg = n;
        prev_cnt = int'(slip_count);
      end
    end
    check(locked === 1'b1, "R7 lock reached", locked, 1);
    check(int'(slip_count) == rot, "R5 slips to lock", slip_count, rot);
    check(out_word === TRAIN, "R2 aligned word", out_word, TRAIN);
    repeat (10) @(negedge clk);
    check(locked === 1'b1 && int'(slip_count) == rot, "R7 lock holds", slip_count, rot);
    cyc = 0;
  endtask

  task automatic t_stream(input int k);
    logic [7:0] prv;
    logic [7:0] cur;
    logic [7:0] held;
    prv = in_word;
    for (int i = 0; i < 6; i++) begin
      cur = 8'(i * 37 + 11);
      in_word = cur;
      @(negedge clk);
      check(out_valid === 1'b1, "R1 valid follows", out_valid, 1);
      check(out_word === slice(prv, cur, k), "R2 window slice", out_word, slice(prv, cur, k));
      prv = cur;
    end
    held = out_word;
    in_valid = 1'b0;
    in_word = 8'hFF;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid drops", out_valid, 0);
    check(out_word === held, "R1 word held", out_word, held);
    in_valid = 1'b1;
    in_word = TRAIN;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_ext_slip();
    // Locked at offset 0 with constant TRAIN input.
    ext_align = 1'b1;
    repeat (3) @(negedge clk);
    check(out_word === rotr(TRAIN, 1), "R3 one bit per edge", out_word, rotr(TRAIN, 1));
    repeat (6) @(negedge clk);
    check(out_word === rotr(TRAIN, 1), "R4 level no extra slip", out_word, rotr(TRAIN, 1));
    ext_align = 1'b0;
    @(negedge clk);
    ext_align = 1'b1;
    repeat (3) @(negedge clk);
    check(out_word === rotr(TRAIN, 2), "R3 second edge", out_word, rotr(TRAIN, 2));
    for (int i = 0; i < 6; i++) begin
      ext_align = 1'b0;
      @(negedge clk);
      ext_align = 1'b1;
      @(negedge clk);
    end
    ext_align = 1'b0;
    repeat (3) @(negedge clk);
    check(out_word === TRAIN, "R3 wraps after eight", out_word, TRAIN);
    ext_align = 1'b1;
    @(negedge clk);
    ext_align = 1'b0;
    repeat (3) @(negedge clk);
    check(out_word === rotr(TRAIN, 1), "R3 offset one before restart", out_word, rotr(TRAIN, 1));
  endtask

  task automatic t_fail();
    int cyc;
    pattern = 8'hA5;
    in_word = 8'h00;
    restart_pulse();
    wait_for(1'b0, "R8 fail reached", cyc);
    check(fail === 1'b1 && locked === 1'b0, "R8 fail not locked", {fail, locked}, 2);
    check(slip_count === 4'd8, "R8 count at limit", slip_count, 8);
    repeat (20) @(negedge clk);
    check(slip_count === 4'd8 && fail === 1'b1, "R8 count stays", slip_count, 8);
  endtask

  task automatic t_overlap();
    int cyc;
    pattern = TRAIN;
    in_word = rotl(TRAIN, 2);
    ext_align = 1'b1;
    repeat (2) @(negedge clk);
    restart_pulse();
    wait_for(1'b0, "R4 masked hunt fails", cyc);
    check(slip_count === 4'd8, "R4 requests counted", slip_count, 8);
    check(out_word === rotl(TRAIN, 2), "R4 masked requests no slip", out_word, rotl(TRAIN, 2));
    ext_align = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lock(0);
    t_stream(0);
    t_lock(5);
    t_stream(5);
    t_lock(0);
    t_ext_slip();
    t_lock(0);  // R9: offset left at one must be cleared, so no slips needed
    t_lock(3);
    t_fail();
    t_overlap();
    t_lock(7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule